// File: doc/BRIEF.md
# SPI Master with Programmable Inter-Word Gap

This block is a mode-0 SPI master that sends a burst of 8-bit words. Each word is taken from a 64-entry transmit FIFO and sent most significant bit first. The word shifted in from the slave at the same time is stored in a 64-entry receive FIFO. A separate divider supplies the serial clock as an enable, `sclk_tick`, which pulses once per half period of SCLK. Each tick toggles SCLK while a word is being shifted.

Between two words of a burst, the master can keep SCLK low for an extra idle time, with chip select still asserted. The idle time is set by a 16-bit gap value, counted in whole SCLK periods. A gap value of zero sends the words back to back. Any non-zero value N is lengthened by three periods, which the wait counter needs to set up, so the idle time is N+3 periods. The shortest non-zero gap is therefore 4 periods.

The host works in four steps:
1. Fill the transmit FIFO.
2. Present the burst length and the gap value.
3. Pulse `start`.
4. Wait for `done`, then drain the receive FIFO.

A length of zero, or a length above the FIFO depth, is refused and raises an error pulse. The gap value is captured when a burst is accepted.

The controller has three states:
- `ST_IDLE`: chip select released and SCLK low.
- `ST_SHIFT`: SCLK toggles on ticks.
- `ST_GAP`: SCLK held low while the gap timer runs.

The transitions are:
- IDLE→SHIFT when a start with a valid length is accepted.
- SHIFT→SHIFT at a word boundary when the gap is zero.
- SHIFT→GAP at a word boundary when the gap is non-zero.
- GAP→SHIFT when the timer expires. The next word is loaded at that moment.
- SHIFT→IDLE at the end of the last word. Chip select is released and `done` pulses.

Top module: `spi_gap_master`

## Requirements
- R1: After reset `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `len_err`=0, `rx_empty`=1 and `tx_full`=0.
- R2: A `start` seen in idle with `burst_len` from 1 to 64 sets `busy`=1 and `cs_n`=0 one cycle later. A length of 0 or above 64 instead gives a one-cycle `len_err` pulse one cycle later, with `busy` staying 0 and `cs_n` staying 1.
- R3: Each word is driven on `mosi` MSB first, and `mosi` changes only while `sclk` is low. `miso` is sampled on each rising SCLK edge. The 8 bits sampled for a word, first bit in bit 7, are written to the receive FIFO.
- R4: With gap value 0, the low time of SCLK between two words equals the low half period inside a word (one half period).
- R5: With gap value N>0, the low time of SCLK between two words is one half period plus N+3 full SCLK periods.
- R6: The smallest non-zero gap value, 1, gives an added idle time of 4 SCLK periods.
- R7: Through a burst, including the gaps, `cs_n` stays 0 and `sclk` stays low whenever no word is shifting. `cs_n` returns to 1 only after the final rising edge of the last word, so a burst of L words shows exactly 8·L rising SCLK edges inside one chip-select window.
- R8: `done` is a single-cycle pulse at the end of the burst. `busy` is 1 from the cycle after the accepted start up to the cycle before `done`, and falls in the cycle `done` is 1.
- R9: `start` is ignored while a burst is active, including in the cycle where `done` is raised. No second burst follows.
- R10: The transmit FIFO holds 64 words. `tx_full` is 1 after 64 writes, and a burst of 64 words sends all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr_en | input | 1 | Write strobe for the transmit FIFO |
| tx_wr_data | input | 8 | Word to append to the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO holds 64 words |
| rx_rd_en | input | 1 | Pop strobe for the receive FIFO |
| rx_rd_data | output | 8 | Oldest word in the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| start | input | 1 | Burst request strobe |
| burst_len | input | 7 | Number of words in the burst |
| gap_cfg | input | 16 | Inter-word gap value in SCLK periods (0 = none) |
| sclk_tick | input | 1 | Half-period enable from the clock divider |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| len_err | output | 1 | One-cycle pulse for a refused burst length |

## Verification
Two events can land in the same core cycle: the end of the final word, which raises `done`, and a new `start` request. The bench provokes this by holding `start` high through a whole burst and releasing it only on the cycle after `done` is seen, so the request is still present on the edge where the controller returns to idle. It is judged correct when `busy` and `cs_n` stay idle afterwards and the chip-select window held exactly eight rising edges per requested word. A second case overlaps a receive-FIFO write with the last rising edge of a 64-word burst. It is judged by reading back every received word in order.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } spi_state_t;

    // serial-clock periods spent arming the wait counter on top of the programmed gap
    localparam int GAP_SETUP = 3;

endpackage

// File: rtl/spi_gap_fifo.sv
module spi_gap_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          do_push, do_pop;

    assign full    = (count_q == CW'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    AST_PUSH_MAKES_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> !empty); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full); // R10

endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = tick && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // smallest legal arm value: (1 + setup 3) periods = 8 half-period ticks
    AST_TMR_MIN_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val >= CW'(8))); // R6
    AST_TMR_ARM_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val[0] == 1'b0)); // R5

endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master
    import spi_gap_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 7,
    parameter int GAP_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    output logic              tx_full,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    output logic              rx_empty,
    input  logic              start,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [GAP_W-1:0]  gap_cfg,
    input  logic              sclk_tick,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              len_err
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int TMR_W = GAP_W + 2;

    spi_state_t          state_q, state_d;
    logic [DATA_W-1:0]   sh_q, rx_sh_q;
    logic [BIT_W-1:0]    bit_q;
    logic [LEN_W-1:0]    left_q;
    logic [GAP_W-1:0]    gap_q;

    logic                len_ok, accept, reject;
    logic                rise, fall, word_end, last_word, gap_zero;
    logic                tx_pop, tx_empty, rx_push, rx_full;
    logic [DATA_W-1:0]   tx_head, rx_push_data;
    logic                tmr_load, tmr_expire;
    logic [TMR_W-1:0]    tmr_val;

    // ---------------- request decode ----------------
    assign len_ok    = (burst_len != '0) && (int'(burst_len) <= FIFO_DEPTH);
    assign accept    = start && (state_q == ST_IDLE) && len_ok;
    assign reject    = start && (state_q == ST_IDLE) && !len_ok;

    // ---------------- serial timing decode ----------------
    assign rise      = sclk_tick && (state_q == ST_SHIFT) && !sclk;
    assign fall      = sclk_tick && (state_q == ST_SHIFT) && sclk;
    assign word_end  = fall && (bit_q == BIT_W'(DATA_W - 1));
    assign last_word = (left_q == LEN_W'(1));
    assign gap_zero  = (gap_q == '0);

    assign tx_pop    = accept
                     | (word_end && !last_word && gap_zero)
                     | ((state_q == ST_GAP) && tmr_expire);
    assign tmr_load  = word_end && !last_word && !gap_zero;
    assign tmr_val   = (TMR_W'(gap_q) + TMR_W'(GAP_SETUP)) << 1;

    assign rx_push      = rise && (bit_q == BIT_W'(DATA_W - 1));
    assign rx_push_data = {rx_sh_q[DATA_W-2:0], miso};

    assign mosi = sh_q[DATA_W-1];
    assign busy = (state_q != ST_IDLE);

    // ---------------- storage and gap timer ----------------
    spi_gap_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr_en), .push_data(tx_wr_data),
        .pop(tx_pop), .head(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    spi_gap_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_rd_en), .head(rx_rd_data),
        .full(rx_full), .empty(rx_empty)
    );

    spi_gap_timer #(.CW(TMR_W)) u_gap_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val),
        .tick(sclk_tick), .expire(tmr_expire)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (word_end) begin
                    if (last_word)     state_d = ST_IDLE;
                    else if (gap_zero) state_d = ST_SHIFT;
                    else               state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_expire) state_d = ST_SHIFT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            sh_q    <= '0;
            rx_sh_q <= '0;
            bit_q   <= '0;
            left_q  <= '0;
            gap_q   <= '0;
            done    <= 1'b0;
            len_err <= 1'b0;
        end else begin
            done    <= 1'b0;
            len_err <= reject;
            if (accept) begin
                cs_n   <= 1'b0;
                sh_q   <= tx_head;
                bit_q  <= '0;
                left_q <= burst_len;
                gap_q  <= gap_cfg;
            end
            if (rise) begin
                sclk    <= 1'b1;
                rx_sh_q <= rx_push_data;
            end
            if (fall) begin
                sclk <= 1'b0;
                if (!word_end) begin
                    sh_q  <= sh_q << 1;
                    bit_q <= bit_q + BIT_W'(1);
                end else begin
                    bit_q  <= '0;
                    left_q <= left_q - LEN_W'(1);
                    if (last_word) begin
                        cs_n <= 1'b1;
                        done <= 1'b1;
                    end else if (gap_zero) begin
                        sh_q <= tx_head;
                    end
                end
            end
            if ((state_q == ST_GAP) && tmr_expire) begin
                sh_q <= tx_head;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_SCLK_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R7
    AST_GAP_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (!sclk && !cs_n)); // R7
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_DROPS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8
    AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!busy && cs_n)); // R2
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !len_err); // R9

endmodule

// File: tb/sim_spi_gap_master.sv
module sim_spi_gap_master;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW = 8, DEPTH = 64, LW = 7, GW = 16;
    localparam real TCLK = 5.0;
    localparam int HALF = 4; // core cycles per SCLK half period (tick spacing)

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic tx_wr_en = 0, rx_rd_en = 0, start = 0, sclk_tick = 0;
    logic [DW-1:0] tx_wr_data = '0;
    logic [LW-1:0] burst_len = '0;
    logic [GW-1:0] gap_cfg = '0;
    logic tx_full, rx_empty, sclk, mosi, cs_n, miso, busy, done, len_err;
    logic [DW-1:0] rx_rd_data;

    spi_gap_master #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .LEN_W(LW), .GAP_W(GW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .start(start), .burst_len(burst_len), .gap_cfg(gap_cfg),
        .sclk_tick(sclk_tick), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
        .busy(busy), .done(done), .len_err(len_err)
    );

    int n_tests = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tx_byte(input logic [7:0] seed, input int k);
        return seed ^ 8'((29 * k) + 7);
    endfunction
    function automatic logic [7:0] slv_byte(input logic [7:0] seed, input int k);
        return seed + 8'(53 * k);
    endfunction

    // half-period tick source
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv      <= (tdiv == HALF - 1) ? 0 : tdiv + 1;
        sclk_tick <= (tdiv == HALF - 1);
    end

    // slave model: presents MSB first, shifts on falling SCLK
    logic [7:0] slv_seed = 8'h00;
    logic [7:0] slv_sh = 8'h00;
    int slv_word = 0, slv_bits = 0;
    assign miso = slv_sh[7];
    always @(negedge cs_n) begin
        slv_word = 0; slv_bits = 0;
        slv_sh = slv_byte(slv_seed, 0);
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            slv_bits++;
            if (slv_bits == 8) begin
                slv_bits = 0; slv_word++;
                slv_sh = slv_byte(slv_seed, slv_word);
            end else begin
                slv_sh = slv_sh << 1;
            end
        end
    end

    // line monitor
    logic [7:0] mosi_cap [128];
    int gap_low [128];
    int rise_cnt = 0, intra_bad = 0, release_rises = 0;
    realtime t_fall = 0.0;
    always @(negedge cs_n) begin rise_cnt = 0; intra_bad = 0; end
    always @(negedge sclk) t_fall = $realtime;
    always @(posedge cs_n) release_rises = rise_cnt;
    always @(posedge sclk) begin
        int lowc, w, b;
        lowc = int'(($realtime - t_fall) / TCLK);
        w = rise_cnt / 8;
        b = rise_cnt % 8;
        if (w < 128) begin
            mosi_cap[w] = {mosi_cap[w][6:0], mosi};
            if (b == 0 && w > 0) gap_low[w] = lowc;
            else if (b != 0 && lowc != HALF) intra_bad++;
        end
        rise_cnt++;
    end

    // len | gap | tx seed | slave seed
    localparam int NV = 5;
    localparam logic [38:0] VEC [NV] = '{
        {7'd1, 16'd0, 8'h96, 8'h5A},
        {7'd3, 16'd0, 8'h3C, 8'hC1},
        {7'd2, 16'd1, 8'hF0, 8'h0F},
        {7'd3, 16'd2, 8'h81, 8'h7E},
        {7'd2, 16'd5, 8'h55, 8'hAA}
    };

    task automatic run_burst(input int len, input int gap, input logic [7:0] txs,
                             input logic [7:0] sls, input bit hold_start);
        int guard, bad, n;
        check(tx_full == 1'b0, "R10 tx_full before fill", int'(tx_full), 0);
        for (int k = 0; k < len; k++) begin
            tx_wr_en = 1; tx_wr_data = tx_byte(txs, k);
            @(negedge clk);
        end
        tx_wr_en = 0;
        if (len == DEPTH) check(tx_full == 1'b1, "R10 tx_full after 64 writes", int'(tx_full), 1);
        slv_seed = sls; gap_cfg = GW'(gap); burst_len = LW'(len);
        start = 1;
        @(negedge clk);
        if (!hold_start) start = 0;
        else burst_len = LW'(2);
        check(busy && !cs_n, "R2 accepted start asserts busy/cs_n", int'({busy, cs_n}), 2);
        guard = 0; bad = 0;
        while (!done && guard < 40000) begin
            if (!busy || cs_n) bad++;
            @(negedge clk);
            guard++;
        end
        start = 0;
        check(done == 1'b1, "R8 done observed", int'(done), 1);
        check(!busy && cs_n, "R8 busy low and cs_n high with done", int'({busy, cs_n}), 1);
        check(bad == 0, "R7 cs_n/busy held through burst", bad, 0);
        @(negedge clk);
        check(done == 1'b0, "R8 done lasts one cycle", int'(done), 0);
        check(release_rises == len * 8, "R7 rising edges in cs window", release_rises, len * 8);
        check(intra_bad == 0, "R4 intra-word low half period", intra_bad, 0);
        for (int k = 0; k < len; k++) begin
            check(mosi_cap[k] == tx_byte(txs, k), "R3 mosi word MSB first",
                  int'(mosi_cap[k]), int'(tx_byte(txs, k)));
            if (k > 0) begin
                n = (gap == 0) ? 0 : gap + 3;
                check(gap_low[k] == HALF * (1 + 2 * n),
                      (gap == 0) ? "R4 back-to-back gap" : (gap == 1) ? "R6 minimum gap" : "R5 programmed gap",
                      gap_low[k], HALF * (1 + 2 * n));
            end
        end
        for (int k = 0; k < len; k++) begin
            check(!rx_empty && rx_rd_data == slv_byte(sls, k), "R3 rx word",
                  int'(rx_rd_data), int'(slv_byte(sls, k)));
            rx_rd_en = 1;
            @(negedge clk);
            rx_rd_en = 0;
        end
        check(rx_empty == 1'b1, "R3 rx drained", int'(rx_empty), 1);
    endtask

    task automatic try_reject(input int len);
        burst_len = LW'(len); start = 1;
        @(negedge clk);
        start = 0;
        check(len_err == 1'b1, "R2 len_err on bad length", int'(len_err), 1);
        check(!busy && cs_n, "R2 no burst on bad length", int'({busy, cs_n}), 1);
        @(negedge clk);
        check(len_err == 1'b0, "R2 len_err one cycle", int'(len_err), 0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(cs_n && !sclk && !busy && !done && !len_err, "R1 reset outputs",
              int'({cs_n, sclk, busy, done, len_err}), 16);
        check(rx_empty && !tx_full, "R1 reset fifo flags", int'({rx_empty, tx_full}), 2);

        // vector table
        for (int v = 0; v < NV; v++) begin
            run_burst(int'(VEC[v][38:32]), int'(VEC[v][31:16]), VEC[v][15:8], VEC[v][7:0], 1'b0);
        end

        // R2 refused lengths
        try_reject(0);
        try_reject(65);
        try_reject(127);

        // R9 start held through the burst, including the done cycle
        run_burst(3, 1, 8'h21, 8'h93, 1'b1);
        repeat (40) @(negedge clk);
        check(!busy && cs_n, "R9 no burst after held start", int'({busy, cs_n}), 1);

        // R10 full-depth burst
        run_burst(DEPTH, 0, 8'h0D, 8'h44, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule